// File: doc/BRIEF.md
# Test-access instruction register with opcode decoder

This block holds the 3-bit instruction of a boundary-scan test port. A serial shift stage is clocked on the rising test clock. It preloads a fixed capture pattern and then shifts the new opcode in from the serial data input. A separate parallel stage holds the instruction in force. That stage is written only on the falling test clock edge while the controller sits in Update-IR. The block decodes the held opcode into one registered flag per instruction and a code that names the data register to place between serial input and output.

The TAP state machine is not part of this block. It drives the four one-hot state inputs: Test-Logic-Reset, Capture-IR, Shift-IR and Update-IR. The data registers are also outside. They use the select code and the mode flags. Test-Logic-Reset and the synchronous reset both put the identification opcode into the parallel stage.

Top module: `tap_instr_reg`

## Requirements
- R1: While `rst` is high across a rising and a falling `tck` edge, the shift stage becomes 3'b001 (`ir_tdo` = 1) and the parallel stage becomes 3'b001 with the identification flag set.
- R2: A rising `tck` edge in Capture-IR loads the shift stage with 3'b001. The first bits presented on `ir_tdo` are therefore 1 and then 0.
- R3: Each rising `tck` edge in Shift-IR moves the shift stage one place toward bit 0, with `tdi` entering at bit 2. `ir_tdo` is always bit 0 of the shift stage.
- R4: The parallel stage takes the shift stage contents on the falling `tck` edge in Update-IR. It does not change at the rising edge that enters Update-IR.
- R5: Outside Update-IR and Test-Logic-Reset, the parallel stage keeps its value, including through Capture-IR and Shift-IR.
- R6: A falling `tck` edge in Test-Logic-Reset writes 3'b001 into the parallel stage, and this takes priority over Update-IR.
- R7: Exactly one flag is set, chosen by the held opcode: 000 extest, 001 idcode, 010 sample/preload, 011 clamp, 100 high-Z, 111 bypass.
- R8: `dr_sel` is 2'b00 (boundary register) for 000 and 010. It is 2'b10 (identification register) for 001. It is 2'b01 (bypass bit) for 011, 100 and 111.
- R9: The unused opcodes 101 and 110 set the bypass flag and give `dr_sel` = 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, sampled on both clock edges |
| tdi | input | 1 | Serial data input |
| st_tlr | input | 1 | Controller is in Test-Logic-Reset |
| st_capture_ir | input | 1 | Controller is in Capture-IR |
| st_shift_ir | input | 1 | Controller is in Shift-IR |
| st_update_ir | input | 1 | Controller is in Update-IR |
| ir_tdo | output | 1 | Serial output, bit 0 of the shift stage |
| ir_code | output | 3 | Held instruction opcode |
| is_extest | output | 1 | Extest instruction active |
| is_idcode | output | 1 | Identification instruction active |
| is_sample | output | 1 | Sample/preload instruction active |
| is_clamp | output | 1 | Clamp instruction active |
| is_highz | output | 1 | High-impedance instruction active |
| is_bypass | output | 1 | Bypass instruction active (including unused opcodes) |
| dr_sel | output | 2 | Selected data register: 00 boundary, 01 bypass, 10 identification |

## Verification
The properties assume that at most one state input is high at a time. They also assume each state input stays steady for a whole `tck` period, from just after one rising edge to just after the next, as a real controller holds it. The stimulus changes the state inputs and `tdi` only one nanosecond after a rising edge, so both edges of that period see the same state. Reset is held across full periods so that both stages see it. Each instruction load walks Capture-IR, three Shift-IR cycles and Update-IR in the order a controller would.

// File: rtl/tapir_pkg.sv
package tapir_pkg;
  localparam int IR_W = 3;
  localparam int SEL_W = 2;
  typedef logic [IR_W-1:0] ir_t;

  localparam ir_t OP_EXTEST = 3'b000;
  localparam ir_t OP_IDCODE = 3'b001;
  localparam ir_t OP_SAMPLE = 3'b010;
  localparam ir_t OP_CLAMP  = 3'b011;
  localparam ir_t OP_HIGHZ  = 3'b100;
  localparam ir_t OP_BYPASS = 3'b111;
  localparam ir_t CAPTURE_PAT = 3'b001;

  typedef enum logic [SEL_W-1:0] {
    DR_BOUNDARY = 2'b00,
    DR_BYPASS   = 2'b01,
    DR_IDENT    = 2'b10
  } dr_sel_e;

  typedef struct packed {
    logic extest;
    logic idcode;
    logic sample;
    logic clamp;
    logic highz;
    logic bypass;
  } ir_flags_t;
endpackage

// File: rtl/tapir_shift.sv
module tapir_shift
  import tapir_pkg::*;
#(
  parameter int W = IR_W,
  parameter logic [W-1:0] CAP = CAPTURE_PAT
) (
  input  logic         tck,
  input  logic         rst,
  input  logic         tdi,
  input  logic         capture,
  input  logic         shift,
  output logic [W-1:0] sr_q
);
  // Rising-edge shift stage: capture preloads, shift moves toward bit 0.
  always_ff @(posedge tck) begin
    if (rst)          sr_q <= CAP;
    else if (capture) sr_q <= CAP;
    else if (shift)   sr_q <= {tdi, sr_q[W-1:1]};
  end
endmodule

// File: rtl/tapir_decode.sv
module tapir_decode
  import tapir_pkg::*;
(
  input  ir_t       code,
  output ir_flags_t flags,
  output dr_sel_e   sel
);
  always_comb begin
    flags = '0;
    sel   = DR_BYPASS;
    unique case (code)
      OP_EXTEST: begin flags.extest = 1'b1; sel = DR_BOUNDARY; end
      OP_IDCODE: begin flags.idcode = 1'b1; sel = DR_IDENT;    end
      OP_SAMPLE: begin flags.sample = 1'b1; sel = DR_BOUNDARY; end
      OP_CLAMP:  begin flags.clamp  = 1'b1; sel = DR_BYPASS;   end
      OP_HIGHZ:  begin flags.highz  = 1'b1; sel = DR_BYPASS;   end
      default:   begin flags.bypass = 1'b1; sel = DR_BYPASS;   end
    endcase
  end
endmodule

// File: rtl/tapir_latch.sv
module tapir_latch
  import tapir_pkg::*;
(
  input  logic      tck,
  input  logic      rst,
  input  logic      force_id,
  input  logic      update,
  input  ir_t       sr_q,
  output ir_t       code_q,
  output ir_flags_t flags_q,
  output dr_sel_e   sel_q
);
  ir_t       code_nxt;
  ir_flags_t flags_nxt;
  dr_sel_e   sel_nxt;

  // Reset and Test-Logic-Reset outrank Update-IR.
  always_comb begin
    if (rst || force_id) code_nxt = OP_IDCODE;
    else if (update)     code_nxt = sr_q;
    else                 code_nxt = code_q;
  end

  tapir_decode u_dec (
    .code  (code_nxt),
    .flags (flags_nxt),
    .sel   (sel_nxt)
  );

  // Falling-edge parallel stage with registered decode.
  always_ff @(negedge tck) begin
    code_q  <= code_nxt;
    flags_q <= flags_nxt;
    sel_q   <= sel_nxt;
  end
endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
  import tapir_pkg::*;
(
  input  logic             tck,
  input  logic             rst,
  input  logic             tdi,
  input  logic             st_tlr,
  input  logic             st_capture_ir,
  input  logic             st_shift_ir,
  input  logic             st_update_ir,
  output logic             ir_tdo,
  output logic [IR_W-1:0]  ir_code,
  output logic             is_extest,
  output logic             is_idcode,
  output logic             is_sample,
  output logic             is_clamp,
  output logic             is_highz,
  output logic             is_bypass,
  output logic [SEL_W-1:0] dr_sel
);
  ir_t       shift_q;
  ir_t       code_q;
  ir_flags_t flags_q;
  dr_sel_e   sel_q;

  tapir_shift #(.W(IR_W), .CAP(CAPTURE_PAT)) u_shift (
    .tck     (tck),
    .rst     (rst),
    .tdi     (tdi),
    .capture (st_capture_ir),
    .shift   (st_shift_ir),
    .sr_q    (shift_q)
  );

  tapir_latch u_latch (
    .tck      (tck),
    .rst      (rst),
    .force_id (st_tlr),
    .update   (st_update_ir),
    .sr_q     (shift_q),
    .code_q   (code_q),
    .flags_q  (flags_q),
    .sel_q    (sel_q)
  );

  assign ir_tdo    = shift_q[0];
  assign ir_code   = code_q;
  assign is_extest = flags_q.extest;
  assign is_idcode = flags_q.idcode;
  assign is_sample = flags_q.sample;
  assign is_clamp  = flags_q.clamp;
  assign is_highz  = flags_q.highz;
  assign is_bypass = flags_q.bypass;
  assign dr_sel    = sel_q;
endmodule

// File: rtl/tapir_chk.sv
module tapir_chk (
  input logic       tck,
  input logic       rst,
  input logic       tdi,
  input logic       st_tlr,
  input logic       st_capture_ir,
  input logic       st_shift_ir,
  input logic       st_update_ir,
  input logic       ir_tdo,
  input logic [2:0] ir_code,
  input logic       is_extest,
  input logic       is_idcode,
  input logic       is_sample,
  input logic       is_clamp,
  input logic       is_highz,
  input logic       is_bypass,
  input logic [1:0] dr_sel,
  input logic [2:0] shift_q
);
  assert_capture_R2: assert property (@(posedge tck) disable iff (rst)
    st_capture_ir |=> (shift_q == 3'b001));

  assert_shift_R3: assert property (@(posedge tck) disable iff (rst)
    (st_shift_ir && !st_capture_ir) |=> (shift_q == {$past(tdi), $past(shift_q[2:1])}));

  assert_tdo_R3: assert property (@(posedge tck) disable iff (rst)
    ir_tdo == shift_q[0]);

  assert_update_R4: assert property (@(negedge tck) disable iff (rst)
    (st_update_ir && !st_tlr) |=> (ir_code == $past(shift_q)));

  assert_hold_R5: assert property (@(negedge tck) disable iff (rst)
    (!st_update_ir && !st_tlr) |=> $stable(ir_code));

  assert_tlr_R6: assert property (@(negedge tck) disable iff (rst)
    st_tlr |=> (ir_code == 3'b001));

  assert_onehot_R7: assert property (@(negedge tck) disable iff (rst)
    $onehot({is_extest, is_idcode, is_sample, is_clamp, is_highz, is_bypass}));

  assert_sel_R8: assert property (@(negedge tck) disable iff (rst)
    ((is_extest || is_sample) == (dr_sel == 2'b00)) && (is_idcode == (dr_sel == 2'b10)));
endmodule

bind tap_instr_reg tapir_chk u_chk (
  .tck           (tck),
  .rst           (rst),
  .tdi           (tdi),
  .st_tlr        (st_tlr),
  .st_capture_ir (st_capture_ir),
  .st_shift_ir   (st_shift_ir),
  .st_update_ir  (st_update_ir),
  .ir_tdo        (ir_tdo),
  .ir_code       (ir_code),
  .is_extest     (is_extest),
  .is_idcode     (is_idcode),
  .is_sample     (is_sample),
  .is_clamp      (is_clamp),
  .is_highz      (is_highz),
  .is_bypass     (is_bypass),
  .dr_sel        (dr_sel),
  .shift_q       (shift_q)
);

// File: tb/test_tap_instr_reg.sv
module test_tap_instr_reg;
  logic tck = 1'b0;
  logic rst = 1'b1;
  logic tdi = 1'b0;
  logic st_tlr = 1'b0, st_capture_ir = 1'b0, st_shift_ir = 1'b0, st_update_ir = 1'b0;
  logic       ir_tdo;
  logic [2:0] ir_code;
  logic is_extest, is_idcode, is_sample, is_clamp, is_highz, is_bypass;
  logic [1:0] dr_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 tck = ~tck;

  tap_instr_reg i_tap_instr_reg (
    .tck(tck), .rst(rst), .tdi(tdi),
    .st_tlr(st_tlr), .st_capture_ir(st_capture_ir),
    .st_shift_ir(st_shift_ir), .st_update_ir(st_update_ir),
    .ir_tdo(ir_tdo), .ir_code(ir_code),
    .is_extest(is_extest), .is_idcode(is_idcode), .is_sample(is_sample),
    .is_clamp(is_clamp), .is_highz(is_highz), .is_bypass(is_bypass),
    .dr_sel(dr_sel)
  );

  // Expected values: kind 0 = opcode, flags and select; 1 = serial output; 2 = opcode only.
  typedef struct {
    string      req;
    int         kind;
    logic [2:0] code;
    logic       tdo;
  } exp_t;
  exp_t sb_q[$];
  event mon_ev;

  // Flag order {extest, idcode, sample, clamp, highz, bypass}.
  function automatic logic [5:0] exp_flags(input logic [2:0] c);
    case (c)
      3'b000:  return 6'b100000;
      3'b001:  return 6'b010000;
      3'b010:  return 6'b001000;
      3'b011:  return 6'b000100;
      3'b100:  return 6'b000010;
      default: return 6'b000001;
    endcase
  endfunction

  function automatic logic [1:0] exp_sel(input logic [2:0] c);
    case (c)
      3'b000, 3'b010: return 2'b00;
      3'b001:         return 2'b10;
      default:        return 2'b01;
    endcase
  endfunction

  task automatic push(input string req, input int kind, input logic [2:0] code, input logic tdo);
    exp_t e;
    e.req = req; e.kind = kind; e.code = code; e.tdo = tdo;
    sb_q.push_back(e);
    -> mon_ev;
  endtask

  // Monitor: pops every queued item and compares it with the ports.
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        logic [5:0] fl;
        e = sb_q.pop_front();
        fl = {is_extest, is_idcode, is_sample, is_clamp, is_highz, is_bypass};
        checks++;
        if (e.kind == 1) begin
          if (ir_tdo !== e.tdo) begin
            errors++;
            $display("FAIL %s: ir_tdo=%b expected %b", e.req, ir_tdo, e.tdo);
          end
        end else if (e.kind == 2) begin
          if (ir_code !== e.code) begin
            errors++;
            $display("FAIL %s: ir_code=%b expected %b", e.req, ir_code, e.code);
          end
        end else begin
          if (ir_code !== e.code || fl !== exp_flags(e.code) || dr_sel !== exp_sel(e.code)) begin
            errors++;
            $display("FAIL %s: code=%b flags=%b sel=%b expected code=%b flags=%b sel=%b",
                     e.req, ir_code, fl, dr_sel, e.code, exp_flags(e.code), exp_sel(e.code));
          end
        end
      end
    end
  end

  // One controller state per clock period, applied just after the rising edge.
  task automatic step(input logic r, input logic tl, input logic cap,
                      input logic sh, input logic up, input logic d);
    @(posedge tck);
    #1;
    rst = r; st_tlr = tl; st_capture_ir = cap; st_shift_ir = sh; st_update_ir = up; tdi = d;
    @(negedge tck);
    #1;
  endtask

  logic [2:0] cur;

  task automatic load(input logic [2:0] c);
    step(0, 0, 1, 0, 0, 0);
    push("R5 capture", 2, cur, 1'b0);
    step(0, 0, 0, 1, 0, c[0]);
    push("R2 first bit", 1, 3'b000, 1'b1);
    push("R5 shift", 2, cur, 1'b0);
    step(0, 0, 0, 1, 0, c[1]);
    push("R2 second bit", 1, 3'b000, 1'b0);
    push("R5 shift", 2, cur, 1'b0);
    step(0, 0, 0, 1, 0, c[2]);
    push("R2 third bit", 1, 3'b000, 1'b0);
    push("R5 shift", 2, cur, 1'b0);
    @(posedge tck);
    #1;
    st_shift_ir = 1'b0; st_update_ir = 1'b1;
    push("R4 not at rising edge", 2, cur, 1'b0);
    push("R3 shifted word lsb", 1, 3'b000, c[0]);
    @(negedge tck);
    #1;
    cur = c;
    if (c == 3'b101 || c == 3'b110) push("R9 unused opcode", 0, c, 1'b0);
    else                            push("R7 R8 decode", 0, c, 1'b0);
    push("R4 falling edge update", 2, c, 1'b0);
    step(0, 0, 0, 0, 0, 0);
    push("R5 idle hold", 2, c, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cur = 3'b001;
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    push("R1 reset code", 0, 3'b001, 1'b0);
    push("R1 reset shift", 1, 3'b000, 1'b1);
    step(0, 0, 0, 0, 0, 0);

    for (int c = 0; c < 8; c++) load(3'(c));

    // R6: Test-Logic-Reset forces the identification opcode.
    step(0, 1, 0, 0, 0, 0);
    cur = 3'b001;
    push("R6 tlr", 0, 3'b001, 1'b0);
    step(0, 0, 0, 0, 0, 0);
    load(3'b111);
    // Load a new word, then TLR together with update: TLR wins.
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 1);
    step(0, 1, 0, 0, 1, 0);
    cur = 3'b001;
    push("R6 tlr over update", 0, 3'b001, 1'b0);
    step(0, 0, 0, 0, 0, 0);

    // R5: capture and shift without update leave the opcode alone.
    load(3'b010);
    step(0, 0, 1, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, 1);
    push("R5 long shift no update", 0, 3'b010, 1'b0);

    // R1: reset again from a non-default opcode.
    load(3'b100);
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    cur = 3'b001;
    push("R1 reset again", 0, 3'b001, 1'b0);
    push("R1 reset shift again", 1, 3'b000, 1'b1);

    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule